// File: doc/BRIEF.md
# Page and Burst Address Sequencer

This block generates the 13-bit word address for a memory arranged as 256 pages of 32 words each. The upper eight address bits pick the page and the lower five pick the word inside it. A controller loads a start address with a one-cycle strobe. It then issues one-cycle advance strobes, and on each strobe the sequencer moves to the next address according to a 2-bit mode input.

Page mode loops over the words of one page forever. Burst mode also steps through the words of the current page, but it moves to the next page only after it has come back around to the word offset it started from. The word offset captured at load time is kept as the reference for that decision. Word mode holds the address and reports that the single-word access is done. Every accepted load or advance is answered with a one-cycle acknowledge pulse, so the controller can pace its accesses on it.

Top module: `pgb_addr_seq`

## Requirements
- R1: The address output is 13 bits wide. Bits 12:5 are the page number and bits 4:0 are the word number within that page.
- R2: When `load_i` is high at a clock edge, `addr_o` equals `load_addr_i` from the following cycle onward.
- R3: A load stores bits 4:0 of `load_addr_i` as the reference word offset. Only a load or a reset changes this reference.
- R4: Page mode is `mode_i` = 01. On an advance, the word field becomes (word+1) mod 32 and the page field does not change.
- R5: Burst mode is `mode_i` = 10. On an advance, the word field becomes (word+1) mod 32. If that new word equals the reference offset, the page field also increments.
- R6: In burst mode the page field wraps from 255 to 0, so an advance past 0x1FFF continues at page 0.
- R7: Word mode is `mode_i` = 00. An advance leaves `addr_o` unchanged and raises `done_o` for exactly one cycle.
- R8: The reserved code `mode_i` = 11 behaves exactly like word mode.
- R9: When `load_i` and `adv_i` are high in the same cycle, only the load takes effect.
- R10: A synchronous active-high `rst` clears the address and the reference offset to 0 and drives `done_o` and `ack_o` low.
- R11: `ack_o` is high for exactly the one cycle that follows each accepted load or advance. It is low after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-cycle strobe that loads the start address |
| load_addr_i | input | 13 | Start address: page in bits 12:5, word in bits 4:0 |
| adv_i | input | 1 | One-cycle strobe that advances to the next address |
| mode_i | input | 2 | 00 word, 01 page, 10 burst, 11 treated as word |
| addr_o | output | 13 | Current address |
| done_o | output | 1 | One-cycle pulse after an advance in word mode |
| ack_o | output | 1 | One-cycle pulse after any accepted load or advance |

## Verification
A corrupted reference offset does not show up in page or word mode. It appears only in burst mode, as a page increment at the wrong word, and it can take up to 32 advances after a load before that increment is due. The bench therefore runs long bursts from several start offsets, including the one left by reset. A stuck or miscounted word field is visible on `addr_o` one cycle after the next advance. A wrong load-versus-advance priority is visible one cycle after the colliding strobes.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

    typedef enum logic [1:0] {
        MODE_WORD  = 2'b00,
        MODE_PAGE  = 2'b01,
        MODE_BURST = 2'b10,
        MODE_RSVD  = 2'b11
    } seq_mode_e;

    // One-hot view of the stepping rule chosen by the mode input
    typedef struct packed {
        logic hold;
        logic page;
        logic burst;
    } mode_sel_t;

endpackage

// File: rtl/pgb_mode_decode.sv
module pgb_mode_decode
    import pgb_pkg::*;
#(
    parameter bit RSVD_AS_WORD = 1'b1
) (
    input  logic [1:0] mode_i,
    output mode_sel_t  sel_o
);

    seq_mode_e mode;
    assign mode = seq_mode_e'(mode_i);

    generate
        if (RSVD_AS_WORD) begin : g_rsvd_hold
            always_comb begin
                sel_o = '0;
                unique case (mode)
                    MODE_PAGE:  sel_o.page  = 1'b1;
                    MODE_BURST: sel_o.burst = 1'b1;
                    default:    sel_o.hold  = 1'b1;
                endcase
            end
        end else begin : g_rsvd_page
            always_comb begin
                sel_o = '0;
                unique case (mode)
                    MODE_WORD:  sel_o.hold  = 1'b1;
                    MODE_BURST: sel_o.burst = 1'b1;
                    default:    sel_o.page  = 1'b1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/pgb_word_step.sv
module pgb_word_step #(
    parameter int WORD_W = 5
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] ref_i,
    output logic [WORD_W-1:0] next_o,
    output logic              hit_ref_o
);

    // Natural wrap of a WORD_W-bit counter gives the 31 -> 0 turnaround
    assign next_o    = word_i + {{(WORD_W-1){1'b0}}, 1'b1};
    assign hit_ref_o = (next_o == ref_i);

endmodule

// File: rtl/pgb_page_step.sv
module pgb_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0] next_o,
    output logic              wrap_o
);

    assign next_o = page_i + {{(PAGE_W-1){1'b0}}, 1'b1};
    assign wrap_o = &page_i;

endmodule

// File: rtl/pgb_addr_seq.sv
module pgb_addr_seq
    import pgb_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int WORD_W = 5,
    parameter int ADDR_W = PAGE_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              ack_o
);

    localparam logic [WORD_W-1:0] WORD_ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] ref_word;
        logic              done;
        logic              ack;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [PAGE_W-1:0] page_q, page_next;
    logic [WORD_W-1:0] word_q, word_next;
    logic              hit_ref, page_wrap;
    mode_sel_t         sel;

    assign page_q = st_q.addr[ADDR_W-1:WORD_W];
    assign word_q = st_q.addr[WORD_W-1:0];

    pgb_mode_decode #(.RSVD_AS_WORD(1'b1)) u_mode (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    pgb_word_step #(.WORD_W(WORD_W)) u_word (
        .word_i    (word_q),
        .ref_i     (st_q.ref_word),
        .next_o    (word_next),
        .hit_ref_o (hit_ref)
    );

    pgb_page_step #(.PAGE_W(PAGE_W)) u_page (
        .page_i (page_q),
        .next_o (page_next),
        .wrap_o (page_wrap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ack  = 1'b0;
        if (load_i) begin
            st_d.addr     = load_addr_i;
            st_d.ref_word = load_addr_i[WORD_W-1:0];
            st_d.ack      = 1'b1;
        end else if (adv_i) begin
            st_d.ack = 1'b1;
            if (sel.hold) begin
                st_d.done = 1'b1;
            end else if (sel.page) begin
                st_d.addr = {page_q, word_next};
            end else if (sel.burst) begin
                st_d.addr = {(hit_ref ? page_next : page_q), word_next};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign done_o = st_q.done;
    assign ack_o  = st_q.ack;

    // Assertions

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (addr_o == '0 && !done_o && !ack_o));

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(load_addr_i)));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (load_i && adv_i) |=> (!done_o && addr_o == $past(load_addr_i)));

    assert_page_keeps_page_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && mode_i == 2'b01) |=>
        (addr_o[ADDR_W-1:WORD_W] == $past(addr_o[ADDR_W-1:WORD_W]) &&
         addr_o[WORD_W-1:0] == $past(addr_o[WORD_W-1:0]) + WORD_ONE));

    assert_burst_word_step_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && mode_i == 2'b10) |=>
        (addr_o[WORD_W-1:0] == $past(addr_o[WORD_W-1:0]) + WORD_ONE));

    assert_burst_page_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && mode_i == 2'b10 && hit_ref && page_wrap) |=>
        (addr_o[ADDR_W-1:WORD_W] == '0));

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=>
        ($stable(addr_o) && done_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ack_o && $past(adv_i) && !$past(load_i)));

    assert_ack_cause_R11: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ($past(load_i) || $past(adv_i)));

    assert_ref_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.ref_word));

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot(sel));

endmodule

// File: tb/pgb_addr_seq_bench.sv
`timescale 1ns/1ps
module pgb_addr_seq_bench;

    localparam int PW = 8;
    localparam int WW = 5;
    localparam int AW = PW + WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic          adv = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] laddr = '0;
    logic [AW-1:0] addr;
    logic          done, ack;

    int vecs = 0;
    int errs = 0;
    logic [AW-1:0] e_addr = '0;
    logic [WW-1:0] e_ref = '0;
    logic          e_done = 1'b0;
    logic          e_ack = 1'b0;

    always #2.5 clk = ~clk;

    pgb_addr_seq u_pgb_addr_seq (
        .clk(clk), .rst(rst), .load_i(load), .load_addr_i(laddr),
        .adv_i(adv), .mode_i(mode), .addr_o(addr), .done_o(done), .ack_o(ack)
    );

    function automatic logic [AW-1:0] f_next(logic [AW-1:0] a, logic [WW-1:0] r,
                                             logic [1:0] m);
        logic [PW-1:0] pg;
        logic [WW-1:0] wd;
        pg = a[AW-1:WW];
        wd = a[WW-1:0] + 1'b1;
        case (m)
            2'b01:   return {pg, wd};
            2'b10:   return (wd == r) ? {pg + 1'b1, wd} : {pg, wd};
            default: return a;
        endcase
    endfunction

    task automatic check(string tag);
        vecs++;
        if (addr !== e_addr || done !== e_done || ack !== e_ack) begin
            errs++;
            $display("FAIL %s: addr=%h done=%b ack=%b expected addr=%h done=%b ack=%b",
                     tag, addr, done, ack, e_addr, e_done, e_ack);
        end
    endtask

    task automatic apply(logic r, logic l, logic [AW-1:0] la, logic a,
                         logic [1:0] m, string tag);
        rst = r; load = l; laddr = la; adv = a; mode = m;
        if (r) begin
            e_addr = '0; e_ref = '0; e_done = 1'b0; e_ack = 1'b0;
        end else if (l) begin
            e_addr = la; e_ref = la[WW-1:0]; e_done = 1'b0; e_ack = 1'b1;
        end else if (a) begin
            e_done = (m == 2'b00 || m == 2'b11);
            e_addr = f_next(e_addr, e_ref, m);
            e_ack  = 1'b1;
        end else begin
            e_done = 1'b0; e_ack = 1'b0;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        apply(1, 0, '0, 0, 2'b00, "R10 reset");
        apply(1, 1, 13'h1ABC, 1, 2'b10, "R10 reset over load");
        // Burst without a load: reference offset from reset is 0
        for (int i = 0; i < 40; i++) apply(0, 0, '0, 1, 2'b10, "R10 ref zero burst");
        // R1 field layout
        apply(0, 1, {8'd5, 5'd7}, 0, 2'b00, "R2 R3 load");
        vecs++;
        if (addr[AW-1:WW] !== 8'd5 || addr[WW-1:0] !== 5'd7) begin
            errs++;
            $display("FAIL R1: page=%0d word=%0d expected page=5 word=7",
                     addr[AW-1:WW], addr[WW-1:0]);
        end
        for (int i = 0; i < 70; i++) apply(0, 0, '0, 1, 2'b01, "R4 page loop");
        for (int i = 0; i < 70; i++) apply(0, 0, '0, 1, 2'b10, "R5 burst");
        apply(0, 1, 13'h1FFE, 0, 2'b00, "R3 load top");
        for (int i = 0; i < 40; i++) apply(0, 0, '0, 1, 2'b10, "R6 page wrap");
        apply(0, 0, '0, 1, 2'b00, "R7 word hold");
        apply(0, 0, '0, 0, 2'b00, "R7 done single");
        apply(0, 0, '0, 1, 2'b11, "R8 reserved");
        apply(0, 1, 13'h0123, 1, 2'b10, "R9 load wins");
        apply(0, 1, 13'h0444, 1, 2'b00, "R9 load wins word");
        apply(0, 0, '0, 0, 2'b10, "R11 idle");
        // Page mode must not disturb the reference offset
        apply(0, 1, {8'd9, 5'd20}, 0, 2'b00, "R3 load");
        for (int i = 0; i < 7; i++) apply(0, 0, '0, 1, 2'b01, "R3 page move");
        for (int i = 0; i < 40; i++) apply(0, 0, '0, 1, 2'b10, "R3 burst ref kept");
        for (int i = 0; i < 5000; i++) begin
            logic r, l, a;
            r = ($urandom % 97) == 0;
            l = ($urandom % 12) == 0;
            a = ($urandom % 4) != 0;
            apply(r, l, AW'($urandom), a, 2'($urandom), "R11 random mix");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule